// File: doc/BRIEF.md
# Cascaded FIFO Chain

This block builds one deep first-in first-out queue on a single clock from a series of smaller power-of-two FIFO stages. The stage sizes halve along the chain, starting at `2**FIRST_LOG2` entries. With the defaults of 16, 8 and 4 entries the chain holds 28 words, which is not a power of two. This suits a memory budget that a power-of-two queue of the next size up would exceed.

Words enter the first stage through a write port with a valid strobe and a full flag. They leave the last stage through a show-ahead read port. In a show-ahead port the oldest word is on the data output whenever the empty flag is low, and a read enable pops it. Between each pair of neighbouring stages a small transfer unit moves words forward. It reads the upstream stage in one cycle, holds the word in a register, and writes it into the downstream stage in the next cycle. To keep that in-flight word from overflowing the next stage, a read happens only while the downstream stage has at least two free entries.

The block also reports its fixed fill latency and its live occupancy. The occupancy count includes words held in the transfer registers. `STAGES` must be at least 2, and `FIRST_LOG2 - STAGES + 1` must be at least 1 so that every stage has at least two entries.

Top module: `cascaded_fifo_chain`

## Requirements
- R1: While and after a synchronous reset with no traffic, empty is 1, full is 0 and occupancy is 0.
- R2: Words leave in exactly the order in which they were accepted. Whenever empty is 0, rd_data shows the oldest word still held.
- R3: No stage is ever written while it is full. After a run of writes with no reads, full rises and stays high. Occupancy then settles between TOTAL-(STAGES-1) and TOTAL, where TOTAL is the sum of 2**(FIRST_LOG2-i) over the stages.
- R4: A write presented while full is 1 is dropped: occupancy does not change and the word never appears at the output.
- R5: A read presented while empty is 1 is dropped: occupancy stays the same, and later words still come out in order.
- R6: At every cycle, occupancy equals the number of accepted writes minus the number of accepted reads since reset, counting words in flight between stages.
- R7: A single word written into an idle empty chain lowers empty after exactly 2*STAGES-1 rising edges, counting the edge that accepts the write. latency_cycles always reports 2*STAGES-1.
- R8: A transfer unit reads its upstream stage only while that stage holds a word and the downstream stage holds at most its depth minus two. The word lands downstream on the next edge, so each downstream stage may end one entry short of full when the chain stalls.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Shared clock for all stages |
| rst | input | 1 | Synchronous reset, active high |
| wr_valid | input | 1 | Write request; accepted when full is 0 |
| wr_data | input | DATA_W | Word to write |
| full | output | 1 | First stage is full; writes are dropped |
| rd_en | input | 1 | Pop the oldest word; accepted when empty is 0 |
| rd_data | output | DATA_W | Oldest word (show-ahead) |
| empty | output | 1 | Last stage is empty |
| occupancy | output | clog2(TOTAL+1) | Words held in the chain, including words in flight |
| latency_cycles | output | 8 | Constant fill latency in clock edges |

## Verification
The bench goes after several corner cases, each of which a wrong design would show in a visible way:
- **Handoff gate.** A gate that ignored the almost-full state would let an in-flight word land on a full stage. That corrupts data, or shows up as a lost word once the chain has been filled with no reads and then drained.
- **Fill latency.** The bench times the fill latency edge by edge. An extra or missing register in a transfer unit moves the fall of empty off 2*STAGES-1.
- **Dropped requests.** Writes against full and reads against empty are hammered. A design that advanced a pointer on them would show an occupancy drift or an out-of-order word.
- **Random traffic.** Random phases that are write-heavy, read-heavy and balanced mix refills with partial drains. These catch occupancy counts that forget words in flight.

// File: rtl/fifo_chain_pkg.sv
package fifo_chain_pkg;

  // Address width of stage idx: depths halve along the chain.
  function automatic int stage_log2(input int first_log2, input int idx);
    return first_log2 - idx;
  endfunction

  function automatic int stage_depth(input int first_log2, input int idx);
    return 1 << stage_log2(first_log2, idx);
  endfunction

  // Sum of all stage depths.
  function automatic int chain_capacity(input int first_log2, input int stages);
    int acc;
    acc = 0;
    for (int i = 0; i < stages; i++) acc += stage_depth(first_log2, i);
    return acc;
  endfunction

  // Lowest settled fill after a stall: each downstream stage may stop one short.
  function automatic int chain_floor(input int first_log2, input int stages);
    return chain_capacity(first_log2, stages) - (stages - 1);
  endfunction

  // Edges from write acceptance to empty falling: one for the first stage,
  // two per handoff (read into the hold register, write downstream).
  function automatic int chain_latency(input int stages);
    return 2 * stages - 1;
  endfunction

endpackage

// File: rtl/chain_stage_fifo.sv
module chain_stage_fifo #(
  parameter int AW     = 2,
  parameter int DATA_W = 8,
  parameter int CNT_W  = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic [DATA_W-1:0] wr_data,
  input  logic              rd_en,
  output logic [DATA_W-1:0] rd_data,
  output logic [CNT_W-1:0]  count,
  output logic              full,
  output logic              afull,
  output logic              empty
);
  localparam int DEPTH = 1 << AW;

  logic [DATA_W-1:0] mem [DEPTH];
  logic [AW-1:0]     wr_ptr;
  logic [AW-1:0]     rd_ptr;
  logic              push_ok;
  logic              pop_ok;

  assign full    = (count == CNT_W'(DEPTH));
  assign afull   = (count == CNT_W'(DEPTH - 1));
  assign empty   = (count == '0);
  assign push_ok = wr_en && !full;
  assign pop_ok  = rd_en && !empty;
  assign rd_data = mem[rd_ptr];

  always_ff @(posedge clk) begin
    if (rst) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
      count  <= '0;
    end else begin
      if (push_ok) wr_ptr <= wr_ptr + 1'b1;
      if (pop_ok)  rd_ptr <= rd_ptr + 1'b1;
      case ({push_ok, pop_ok})
        2'b10:   count <= count + 1'b1;
        2'b01:   count <= count - 1'b1;
        default: count <= count;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (push_ok) mem[wr_ptr] <= wr_data;
  end

endmodule

// File: rtl/chain_link.sv
module chain_link #(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              up_empty,
  input  logic [DATA_W-1:0] up_data,
  input  logic              dn_full,
  input  logic              dn_afull,
  output logic              up_pop,
  output logic              dn_push,
  output logic [DATA_W-1:0] dn_data
);
  logic              busy_q;
  logic [DATA_W-1:0] hold_q;

  // Read only with two free downstream slots: one for the word already
  // in flight, one for the word taken now.
  assign up_pop  = !up_empty && !dn_full && !dn_afull;
  assign dn_push = busy_q;
  assign dn_data = hold_q;

  always_ff @(posedge clk) begin
    if (rst) busy_q <= 1'b0;
    else     busy_q <= up_pop;
  end

  always_ff @(posedge clk) begin
    if (up_pop) hold_q <= up_data;
  end

endmodule

// File: rtl/cascaded_fifo_chain.sv
module cascaded_fifo_chain
  import fifo_chain_pkg::*;
#(
  parameter  int DATA_W     = 16,
  parameter  int STAGES     = 3,
  parameter  int FIRST_LOG2 = 4,
  localparam int TOTAL      = chain_capacity(FIRST_LOG2, STAGES),
  localparam int OCC_W      = $clog2(TOTAL + 1)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_valid,
  input  logic [DATA_W-1:0] wr_data,
  output logic              full,
  input  logic              rd_en,
  output logic [DATA_W-1:0] rd_data,
  output logic              empty,
  output logic [OCC_W-1:0]  occupancy,
  output logic [7:0]        latency_cycles
);
  localparam int CNT_W = FIRST_LOG2 + 1;
  localparam int LAST  = STAGES - 1;
  localparam int LAT   = chain_latency(STAGES);

  // Named internal events, also seen by the bound checker.
  logic [STAGES-1:0] st_push;
  logic [STAGES-1:0] st_pop;
  logic [STAGES-1:0] st_full;
  logic [STAGES-1:0] st_afull;
  logic [STAGES-1:0] st_empty;
  logic [STAGES-2:0] link_go;
  logic [DATA_W-1:0] st_wdata [STAGES];
  logic [DATA_W-1:0] st_rdata [STAGES];
  logic [CNT_W-1:0]  st_cnt   [STAGES];

  // Entry and exit of the chain.
  assign st_push[0]     = wr_valid && !st_full[0];
  assign st_wdata[0]    = wr_data;
  assign st_pop[LAST]   = rd_en && !st_empty[LAST];
  assign full           = st_full[0];
  assign empty          = st_empty[LAST];
  assign rd_data        = st_rdata[LAST];
  assign latency_cycles = 8'(LAT);

  for (genvar i = 0; i < STAGES; i++) begin : g_stage
    chain_stage_fifo #(
      .AW    (stage_log2(FIRST_LOG2, i)),
      .DATA_W(DATA_W),
      .CNT_W (CNT_W)
    ) u_fifo (
      .clk    (clk),
      .rst    (rst),
      .wr_en  (st_push[i]),
      .wr_data(st_wdata[i]),
      .rd_en  (st_pop[i]),
      .rd_data(st_rdata[i]),
      .count  (st_cnt[i]),
      .full   (st_full[i]),
      .afull  (st_afull[i]),
      .empty  (st_empty[i])
    );
  end

  for (genvar j = 0; j < STAGES - 1; j++) begin : g_link
    chain_link #(
      .DATA_W(DATA_W)
    ) u_link (
      .clk     (clk),
      .rst     (rst),
      .up_empty(st_empty[j]),
      .up_data (st_rdata[j]),
      .dn_full (st_full[j+1]),
      .dn_afull(st_afull[j+1]),
      .up_pop  (link_go[j]),
      .dn_push (st_push[j+1]),
      .dn_data (st_wdata[j+1])
    );
    assign st_pop[j] = link_go[j];
  end

  // Occupancy: stage counts plus words parked in the hold registers.
  always_comb begin
    int acc;
    acc = 0;
    for (int i = 0; i < STAGES; i++) acc += int'(st_cnt[i]);
    for (int j = 1; j < STAGES; j++) acc += int'(st_push[j]);
    occupancy = OCC_W'(acc);
  end

endmodule

// File: rtl/fifo_chain_checker.sv
module fifo_chain_checker
  import fifo_chain_pkg::*;
#(
  parameter  int STAGES     = 3,
  parameter  int FIRST_LOG2 = 4,
  localparam int OCC_W      = $clog2(chain_capacity(FIRST_LOG2, STAGES) + 1)
) (
  input logic              clk,
  input logic              rst,
  input logic              wr_valid,
  input logic              rd_en,
  input logic              full,
  input logic              empty,
  input logic [OCC_W-1:0]  occupancy,
  input logic [STAGES-1:0] st_full,
  input logic [STAGES-1:0] st_push,
  input logic [STAGES-2:0] link_go
);
  logic past_ok = 1'b0;

  always_ff @(posedge clk) past_ok <= !rst;

  for (genvar i = 0; i < STAGES; i++) begin : g_stage_chk
    // R3: a stage never receives a write request while full
    assert_no_overflow_R3: assert property (@(posedge clk) disable iff (rst)
      st_push[i] |-> !st_full[i]);
  end

  for (genvar j = 0; j < STAGES - 1; j++) begin : g_link_chk
    // R8: a word taken upstream lands downstream on the next edge
    assert_handoff_lands_R8: assert property (@(posedge clk) disable iff (rst)
      link_go[j] |=> st_push[j+1]);
  end

  // R6: occupancy moves by accepted writes minus accepted reads
  assert_occupancy_track_R6: assert property (@(posedge clk) disable iff (rst || !past_ok)
    int'(occupancy) == int'($past(occupancy)) + int'($past(wr_valid && !full))
                       - int'($past(rd_en && !empty)));

  // R6: nothing held means nothing readable
  assert_zero_means_empty_R6: assert property (@(posedge clk) disable iff (rst)
    (occupancy == '0) |-> empty);

  // R3: a full chain holds at least the first stage's depth
  assert_full_floor_R3: assert property (@(posedge clk) disable iff (rst)
    full |-> (int'(occupancy) >= stage_depth(FIRST_LOG2, 0)));

endmodule

bind cascaded_fifo_chain fifo_chain_checker #(
  .STAGES    (STAGES),
  .FIRST_LOG2(FIRST_LOG2)
) u_chain_chk (
  .clk      (clk),
  .rst      (rst),
  .wr_valid (wr_valid),
  .rd_en    (rd_en),
  .full     (full),
  .empty    (empty),
  .occupancy(occupancy),
  .st_full  (st_full),
  .st_push  (st_push),
  .link_go  (link_go)
);

// File: tb/cascaded_fifo_chain_test.sv
`timescale 1ns/1ps
module cascaded_fifo_chain_test;
  localparam int DW = 16;
  localparam int NS = 3;
  localparam int FL = 4;

  function automatic int bench_total();
    int s;
    s = 0;
    for (int i = 0; i < NS; i++) s += 2 ** (FL - i);
    return s;
  endfunction

  localparam int TOTAL = bench_total();
  localparam int FLOOR = TOTAL - (NS - 1);
  localparam int LAT   = 2 * NS - 1;
  localparam int OW    = $clog2(TOTAL + 1);

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          wr_valid = 1'b0;
  logic [DW-1:0] wr_data = '0;
  logic          rd_en = 1'b0;
  logic          full;
  logic [DW-1:0] rd_data;
  logic          empty;
  logic [OW-1:0] occupancy;
  logic [7:0]    latency_cycles;

  cascaded_fifo_chain #(.DATA_W(DW), .STAGES(NS), .FIRST_LOG2(FL)) uut (
    .clk(clk), .rst(rst), .wr_valid(wr_valid), .wr_data(wr_data), .full(full),
    .rd_en(rd_en), .rd_data(rd_data), .empty(empty), .occupancy(occupancy),
    .latency_cycles(latency_cycles)
  );

  always #10 clk = ~clk;

  int checks = 0;
  int fails = 0;
  bit finished = 1'b0;
  logic [DW-1:0] q[$];

  task automatic check(input bit ok, input string req, input string what,
                       input longint act, input longint exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  task automatic finish_run();
    if (!finished) begin
      finished = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  endtask

  // Called at a falling edge; returns at the next falling edge.
  task automatic step(input logic w, input logic [DW-1:0] d, input logic r);
    bit wacc;
    bit racc;
    check(int'(occupancy) == q.size(), "R6", "occupancy", occupancy, q.size());
    wr_valid = w;
    wr_data  = d;
    rd_en    = r;
    wacc = w && !full;
    racc = r && !empty;
    if (racc) begin
      check(rd_data == q[0], "R2", "read order", rd_data, q[0]);
      void'(q.pop_front());
    end
    if (wacc) q.push_back(d);
    @(posedge clk);
    @(negedge clk);
    wr_valid = 1'b0;
    rd_en    = 1'b0;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    checks++;
    fails++;
    $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
    finish_run();
  end

  initial begin
    int occ_before;
    void'($urandom(32'd7321));
    repeat (3) @(negedge clk);
    rst = 1'b0;
    // R1: reset state
    check(empty == 1'b1, "R1", "empty after reset", empty, 1);
    check(full == 1'b0, "R1", "full after reset", full, 0);
    check(occupancy == '0, "R1", "occupancy after reset", occupancy, 0);
    check(int'(latency_cycles) == LAT, "R7", "latency port", latency_cycles, LAT);

    // R7: single word fill latency
    step(1'b1, 16'h1234, 1'b0);
    check(empty == (1 < LAT), "R7", "empty after edge 1", empty, (1 < LAT));
    for (int k = 2; k <= LAT; k++) begin
      step(1'b0, '0, 1'b0);
      check(empty == (k < LAT), "R7", $sformatf("empty after edge %0d", k), empty, (k < LAT));
    end
    step(1'b0, '0, 1'b1);
    check(empty == 1'b1, "R2", "empty after single pop", empty, 1);

    // R5: reads against empty are dropped
    repeat (4) step(1'b0, '0, 1'b1);
    check(occupancy == '0, "R5", "occupancy after empty reads", occupancy, 0);
    check(empty == 1'b1, "R5", "empty after empty reads", empty, 1);
    step(1'b1, 16'hBEEF, 1'b0);
    repeat (LAT) step(1'b0, '0, 1'b0);
    check(rd_data == 16'hBEEF, "R5", "word after empty reads", rd_data, 16'hBEEF);
    step(1'b0, '0, 1'b1);

    // R3 / R4 / R8: fill with no reads
    for (int n = 0; n < TOTAL + 12; n++) step(1'b1, 16'(16'h4000 + n), 1'b0);
    repeat (12) step(1'b0, '0, 1'b0);
    check(full == 1'b1, "R3", "full after fill", full, 1);
    check(int'(occupancy) <= TOTAL, "R3", "occupancy ceiling", occupancy, TOTAL);
    check(int'(occupancy) >= FLOOR, "R8", "occupancy floor after stall", occupancy, FLOOR);
    occ_before = int'(occupancy);
    repeat (3) step(1'b1, 16'hDEAD, 1'b0);
    check(int'(occupancy) == occ_before, "R4", "occupancy after writes while full",
          occupancy, occ_before);
    check(full == 1'b1, "R4", "full held", full, 1);
    for (int n = 0; n < 4 * TOTAL && q.size() > 0; n++) step(1'b0, '0, 1'b1);
    check(q.size() == 0, "R2", "drain complete", q.size(), 0);
    check(empty == 1'b1 && occupancy == '0, "R6", "empty after drain", occupancy, 0);

    // Random phases: write-heavy, read-heavy, balanced
    for (int n = 0; n < 3000; n++) begin
      int ph;
      int wp;
      int rp;
      ph = (n / 250) % 3;
      wp = (ph == 0) ? 85 : (ph == 1) ? 30 : 60;
      rp = (ph == 0) ? 30 : (ph == 1) ? 85 : 60;
      step(($urandom % 100) < wp, DW'($urandom), ($urandom % 100) < rp);
    end
    for (int n = 0; n < 4 * TOTAL && q.size() > 0; n++) step(1'b0, '0, 1'b1);
    check(q.size() == 0, "R2", "final drain", q.size(), 0);
    check(occupancy == '0, "R6", "final occupancy", occupancy, 0);
    finish_run();
  end

endmodule